// File: doc/BRIEF.md
# Guarded Timer Prescaler with Interrupt Mask

This block is the control core of a general-purpose timer. It holds an 8-bit control register that combines four interrupt enables with a 2-bit prescale select. It also contains the prescaler that the select drives and a free-running up-counter that advances once per prescaler period. The counter raises its own wrap flag. Three more event flags (real-time tick, pulse-accumulator overflow and pulse-accumulator edge) arrive from neighbouring logic. Each enable gates its own flag, and a single registered interrupt request summarises the four gated flags.

The prescale select is guarded. In normal operation software gets exactly one chance to set it, and only during the early part of the run after reset: a write counts only while fewer than `WIN_CYC` bus-cycle enables have been seen. Once that write has been used or the window has passed, the select is frozen until the next reset. When the special-mode input is high, the guard is lifted and the select can be rewritten freely. The enables are never guarded.

A register write takes effect on the clock edge where `wr_en` is high. The read port is combinational. All counting follows `cyc_en`, which marks one bus cycle.

Top module: `tgc_timer_ctl`

## Requirements
- R1: `rd_data` bit 7 is the wrap (overflow) enable, bit 6 the real-time enable, bit 5 the accumulator-overflow enable, bit 4 the accumulator-edge enable, and bits 1:0 the prescale select. A write loads the same positions from `wr_data`.
- R2: After reset `rd_data` is 0x00, `count` is 0, and both `ovf_flag` and `irq` are 0.
- R3: `rd_data` bits 3:2 always read 0, whatever value is written there.
- R4: The four enable bits take `wr_data[7:4]` on every write, in either mode and at any time.
- R5: With `mode_special` low, a write changes the prescale select only if it is the first write since reset and fewer than `WIN_CYC` (default 64) `cyc_en` cycles have elapsed since reset. Any write accepted this way uses up the single chance, and every later write leaves the select unchanged.
- R6: With `mode_special` high, every write loads the prescale select, at any time and any number of times. Such writes do not use up the single chance.
- R7: The counter advances by one every 1, 4, 8 or 16 `cyc_en` cycles for select codes 00, 01, 10 and 11 respectively. The counter holds while `cyc_en` is low. An accepted select write restarts the prescaler period from zero.
- R8: The window of R5 counts only clock edges on which `cyc_en` is high. Clock edges with `cyc_en` low do not shorten it.
- R9: The counter wraps from all-ones to zero, and that wrap sets `ovf_flag`. The flag stays set until a cycle with `ovf_clr` high clears it. If a wrap and a clear fall in the same cycle, the flag stays set.
- R10: `irq` is registered. One edge after the flag pair is present, it equals the OR of four products: enable bit 7 with `ovf_flag`, bit 6 with `ext_flags[2]`, bit 5 with `ext_flags[1]`, and bit 4 with `ext_flags[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-cycle bus-cycle enable |
| mode_special | input | 1 | High lifts the guard on the prescale select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| ext_flags | input | 3 | Event flags: [2] real-time, [1] accumulator overflow, [0] accumulator edge |
| ovf_clr | input | 1 | Clears the wrap flag |
| count | output | CNT_W | Free-running counter value |
| ovf_flag | output | 1 | Counter wrap flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with `CNT_W` set to 8 and `WIN_CYC` left at its default of 64. With the narrow counter, a wrap at divide-by-1 takes at most 256 cycles, so the flag set, hold and clear sequence, and the interrupt that follows it, are cheap to reach. The full-size window keeps the write guard at its real length, so the 63-cycle and 64-cycle cases bracket its exact closing edge. A run with `cyc_en` held low shows that the window counts only bus cycles.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

   localparam int SRC_N  = 4;
   localparam int DIV_MAX = 16;

   typedef enum logic [1:0] {
      PS_DIV1  = 2'b00,
      PS_DIV4  = 2'b01,
      PS_DIV8  = 2'b10,
      PS_DIV16 = 2'b11
   } tgc_ps_e;

   typedef struct packed {
      logic wrap_en;
      logic rti_en;
      logic paov_en;
      logic pae_en;
   } tgc_en_t;

   function automatic logic [4:0] ps_divisor(tgc_ps_e sel);
      case (sel)
         PS_DIV1:  return 5'd1;
         PS_DIV4:  return 5'd4;
         PS_DIV8:  return 5'd8;
         default:  return 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/tgc_win_guard.sv
module tgc_win_guard #(
   parameter int WIN_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_en,
   input  logic mode_special,
   input  logic sel_wr,
   output logic sel_ok,
   output logic win_open,
   output logic sel_used
);

   localparam int CW = $clog2(WIN_CYC + 1);
   localparam logic [CW-1:0] WIN_LIM = CW'(WIN_CYC);

   logic [CW-1:0] win_cnt;
   logic          take_once;

   generate
      if (WIN_CYC < 1) begin : g_bad_win
         $error("tgc_win_guard: WIN_CYC must be at least 1");
      end
   endgenerate

   assign win_open  = (win_cnt < WIN_LIM);
   assign take_once = sel_wr && !mode_special && win_open && !sel_used;
   assign sel_ok    = (sel_wr && mode_special) || take_once;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
      end else if (cyc_en && win_open) begin
         win_cnt <= win_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_used <= 1'b0;
      end else if (take_once) begin
         sel_used <= 1'b1;
      end
   end

endmodule

// File: rtl/tgc_prescale.sv
module tgc_prescale
   import tgc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cyc_en,
   input  logic    restart,
   input  tgc_ps_e sel,
   output logic    tick
);

   localparam int PW = $clog2(DIV_MAX);

   logic [PW-1:0] ph_cnt;
   logic [4:0]    last_ph;
   logic          at_end;

   assign last_ph = ps_divisor(sel) - 5'd1;
   assign at_end  = ({1'b0, ph_cnt} == last_ph);
   assign tick    = cyc_en && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_cnt <= '0;
      end else if (restart) begin
         ph_cnt <= '0;
      end else if (cyc_en) begin
         if (at_end) begin
            ph_cnt <= '0;
         end else begin
            ph_cnt <= ph_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tgc_freerun.sv
module tgc_freerun #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag
);

   logic wrap;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("tgc_freerun: CNT_W must be at least 2");
      end
   endgenerate

   assign wrap = tick && (count == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (tick) begin
         count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
      end else if (wrap) begin
         ovf_flag <= 1'b1;
      end else if (ovf_clr) begin
         ovf_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/tgc_timer_ctl.sv
module tgc_timer_ctl
   import tgc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int WIN_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_en,
   input  logic             mode_special,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   input  logic [2:0]       ext_flags,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             irq
);

   tgc_en_t          en_q;
   logic [1:0]       pr_q;
   logic             sel_ok;
   logic             win_open;
   logic             sel_used;
   logic             tick;
   logic [SRC_N-1:0] flag_vec;
   logic [SRC_N-1:0] req_vec;
   logic             irq_q;
   logic             rsv_unused;

   assign rsv_unused = ^wr_data[3:2];

   // control register: enables free, prescale select guarded
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en) begin
         en_q <= tgc_en_t'(wr_data[7:4]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_q <= 2'b00;
      end else if (sel_ok) begin
         pr_q <= wr_data[1:0];
      end
   end

   assign rd_data = {en_q, 2'b00, pr_q};

   tgc_win_guard #(.WIN_CYC(WIN_CYC)) u_guard (
      .clk          (clk),
      .rst_n        (rst_n),
      .cyc_en       (cyc_en),
      .mode_special (mode_special),
      .sel_wr       (wr_en),
      .sel_ok       (sel_ok),
      .win_open     (win_open),
      .sel_used     (sel_used)
   );

   tgc_prescale u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_en  (cyc_en),
      .restart (sel_ok),
      .sel     (tgc_ps_e'(pr_q)),
      .tick    (tick)
   );

   tgc_freerun #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ovf_clr  (ovf_clr),
      .count    (count),
      .ovf_flag (ovf_flag)
   );

   // flags ordered to match the enable struct, MSB first
   assign flag_vec = {ovf_flag, ext_flags};

   generate
      for (genvar i = 0; i < SRC_N; i++) begin : g_gate
         assign req_vec[i] = en_q[i] & flag_vec[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= |req_vec;
      end
   end

   assign irq = irq_q;

endmodule

// File: rtl/tgc_timer_ctl_chk.sv
module tgc_timer_ctl_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_special,
   input logic             wr_en,
   input logic [1:0]       wr_pr,
   input logic [7:0]       rd_data,
   input logic [1:0]       pr_q,
   input logic             win_open,
   input logic             sel_used,
   input logic             tick,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             ovf_clr,
   input logic [3:0]       req_vec,
   input logic             irq
);

   p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[3:2] == 2'b00);

   p_pr_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_special && !win_open) |=> $stable(pr_q));

   p_pr_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_special && sel_used) |=> $stable(pr_q));

   p_pr_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_special && wr_en) |=> (pr_q == $past(wr_pr)));

   p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == {CNT_W{1'b1}}) |=> ovf_flag);

   p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   p_irq_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_vec) |=> irq);

   p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec == 4'b0000) |=> !irq);

endmodule

bind tgc_timer_ctl tgc_timer_ctl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_special (mode_special),
   .wr_en        (wr_en),
   .wr_pr        (wr_data[1:0]),
   .rd_data      (rd_data),
   .pr_q         (pr_q),
   .win_open     (win_open),
   .sel_used     (sel_used),
   .tick         (tick),
   .count        (count),
   .ovf_flag     (ovf_flag),
   .ovf_clr      (ovf_clr),
   .req_vec      (req_vec),
   .irq          (irq)
);

// File: tb/tgc_timer_ctl_test.sv
module tgc_timer_ctl_test;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam int WIN_CYC    = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cyc_en = 1'b0;
   logic             mode_special = 1'b0;
   logic             wr_en = 1'b0;
   logic [7:0]       wr_data = 8'h00;
   logic [7:0]       rd_data;
   logic [2:0]       ext_flags = 3'b000;
   logic             ovf_clr = 1'b0;
   logic [CNT_W-1:0] count;
   logic             ovf_flag;
   logic             irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tgc_timer_ctl #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cyc_en       (cyc_en),
      .mode_special (mode_special),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_data      (rd_data),
      .ext_flags    (ext_flags),
      .ovf_clr      (ovf_clr),
      .count        (count),
      .ovf_flag     (ovf_flag),
      .irq          (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic special, input logic en);
      @(negedge clk);
      rst_n = 1'b0;
      mode_special = special;
      cyc_en = en;
      wr_en = 1'b0;
      ext_flags = 3'b000;
      ovf_clr = 1'b0;
      ticks(3);
      rst_n = 1'b1;
   endtask

   task automatic reg_write(input logic [7:0] val);
      wr_en = 1'b1;
      wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset(1'b0, 1'b0);
      check("R2 rd_data", 32'(rd_data), 32'h00);
      check("R2 count", 32'(count), 32'h0);
      check("R2 ovf_flag", 32'(ovf_flag), 32'h0);
      check("R2 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_write_once();
      do_reset(1'b0, 1'b1);
      reg_write(8'hFF);
      check("R1 R3 first write", 32'(rd_data), 32'hF3);
      reg_write(8'h0D);
      check("R4 R5 second write", 32'(rd_data), 32'h03);
      reg_write(8'hA0);
      check("R4 enables later", 32'(rd_data), 32'hA3);
   endtask

   task automatic t_window_edge();
      do_reset(1'b0, 1'b1);
      ticks(63);
      cyc_en = 1'b0;
      reg_write(8'h02);
      check("R5 write after 63 cycles", 32'(rd_data), 32'h02);
      do_reset(1'b0, 1'b1);
      ticks(64);
      cyc_en = 1'b0;
      reg_write(8'h02);
      check("R5 write after 64 cycles", 32'(rd_data), 32'h00);
   endtask

   task automatic t_window_gated();
      do_reset(1'b0, 1'b0);
      ticks(100);
      reg_write(8'h01);
      check("R8 idle cycles not counted", 32'(rd_data), 32'h01);
   endtask

   task automatic t_special();
      do_reset(1'b1, 1'b1);
      ticks(100);
      reg_write(8'h01);
      check("R6 late write", 32'(rd_data), 32'h01);
      reg_write(8'h03);
      check("R6 rewrite", 32'(rd_data), 32'h03);
      reg_write(8'h02);
      check("R6 third write", 32'(rd_data), 32'h02);
   endtask

   task automatic t_rates();
      logic [CNT_W-1:0] c0;
      int divs[4] = '{1, 4, 8, 16};
      do_reset(1'b1, 1'b1);
      for (int s = 0; s < 4; s++) begin
         reg_write(8'(s));
         c0 = count;
         ticks(40);
         check($sformatf("R7 rate code %0d", s), 32'(count), 32'(CNT_W'(c0 + CNT_W'(40 / divs[s]))));
      end
      reg_write(8'h03);
      ticks(10);
      reg_write(8'h03);
      c0 = count;
      ticks(10);
      check("R7 restart drops partial period", 32'(count), 32'(c0));
      cyc_en = 1'b0;
      reg_write(8'h00);
      c0 = count;
      ticks(20);
      check("R7 hold without cyc_en", 32'(count), 32'(c0));
      cyc_en = 1'b1;
   endtask

   task automatic t_overflow();
      logic [CNT_W-1:0] c0;
      int n;
      do_reset(1'b1, 1'b1);
      ticks(37);
      reg_write(8'h80);
      c0 = count;
      n = (1 << CNT_W) - int'(c0);
      ticks(n - 1);
      check("R9 no flag before wrap", 32'(ovf_flag), 32'h0);
      ticks(1);
      check("R9 flag on wrap", 32'(ovf_flag), 32'h1);
      check("R9 wrapped count", 32'(count), 32'h0);
      check("R10 irq lags flag", 32'(irq), 32'h0);
      ticks(1);
      check("R10 irq from wrap flag", 32'(irq), 32'h1);
      ticks(4);
      check("R9 flag held", 32'(ovf_flag), 32'h1);
      ovf_clr = 1'b1;
      ticks(1);
      ovf_clr = 1'b0;
      check("R9 flag cleared", 32'(ovf_flag), 32'h0);
      check("R10 irq one edge late", 32'(irq), 32'h1);
      ticks(1);
      check("R10 irq drops", 32'(irq), 32'h0);
   endtask

   task automatic t_ext_gating();
      do_reset(1'b1, 1'b0);
      reg_write(8'h40);
      ext_flags = 3'b011;
      ticks(2);
      check("R10 masked flags", 32'(irq), 32'h0);
      ext_flags = 3'b100;
      ticks(1);
      check("R10 real-time flag", 32'(irq), 32'h1);
      ext_flags = 3'b000;
      ticks(1);
      check("R10 flag gone", 32'(irq), 32'h0);
      reg_write(8'h30);
      ext_flags = 3'b001;
      ticks(1);
      check("R10 edge flag", 32'(irq), 32'h1);
      ext_flags = 3'b100;
      ticks(2);
      check("R10 real-time now masked", 32'(irq), 32'h0);
      ext_flags = 3'b000;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_write_once();
      t_window_edge();
      t_window_gated();
      t_special();
      t_rates();
      t_overflow();
      t_ext_gating();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule